// File: doc/BRIEF.md
# Six-Flag Operand-Shaping ALU

This block is a purely combinational arithmetic logic unit that works on two-word operands (16 bits by default). It has no opcode. Six independent control bits say how the result is formed. Two bits shape operand A: clear it, then complement it. Two more do the same for operand B. One bit selects either the sum or the bitwise AND of the shaped operands. The last bit complements that intermediate value to give the result.

Each operation is a mix of these six bits. The mixes give constants, pass-through, complement, negation, increment, decrement, subtraction in both directions, AND and OR. Two status flags come with the result: one reports that the result is all zeros, the other reports that it is negative in two's complement. The result and both flags follow the inputs within the same cycle, with no clock or reset.

Top module: `flagalu16`

## Requirements
- R1: When `clr_a` is 1, operand A is taken as all zeros before any other shaping.
- R2: When `cpl_a` is 1, operand A is bitwise complemented after the clear step, so `clr_a`=1 with `cpl_a`=1 yields all ones.
- R3: `clr_b` and `cpl_b` shape operand B in the same order: clear first, then complement.
- R4: When `use_sum` is 1, the intermediate value is the sum of the shaped operands modulo 2^WIDTH, and the carry out of the top bit is dropped (7FFF+0001 gives 8000, FFFF+0001 gives 0000).
- R5: When `use_sum` is 0, the intermediate value is the bitwise AND of the shaped operands.
- R6: When `cpl_res` is 1, `res_o` is the bitwise complement of the intermediate value; otherwise it equals the intermediate value.
- R7: `zero_o` is 1 exactly when `res_o` is all zeros.
- R8: `neg_o` is 1 exactly when the top bit of `res_o` is set.
- R9: The control word {clr_a,cpl_a,clr_b,cpl_b,use_sum,cpl_res} gives the constant 0 for 101010, 1 for 111111 and all ones (-1) for 111010, whatever the operands.
- R10: Control word 010011 gives A-B, 000111 gives B-A, 010101 gives A|B, 001111 gives -A, 011111 gives A+1 and 001110 gives A-1.
- R11: The block has no storage: the outputs depend only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| clr_a | input | 1 | Clear operand A |
| cpl_a | input | 1 | Complement operand A after the clear step |
| clr_b | input | 1 | Clear operand B |
| cpl_b | input | 1 | Complement operand B after the clear step |
| use_sum | input | 1 | 1: add shaped operands, 0: AND them |
| cpl_res | input | 1 | Complement the intermediate value |
| res_o | output | WIDTH | Result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result top bit is set |

## Verification
A hand-computed table covers the named operations. The constant patterns show that the operands are ignored. The A-B and B-A entries use the same operands, so a swapped operand shows up as a wrong sign. The increment, decrement and negate entries expose a wrong clear-versus-complement order, because a swapped order changes the constant that is added. Sums across the sign boundary and the all-ones boundary separate a wrapping adder from one that keeps the carry, and they set the negative and zero flags in turn. A sweep of all 64 control words over several operand pairs is then compared with a model written from the requirements, so that each control bit is exercised against every combination of the others.

// File: rtl/flagalu16.sv
module flagalu16 #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             clr_a,
  input  logic             cpl_a,
  input  logic             clr_b,
  input  logic             cpl_b,
  input  logic             use_sum,
  input  logic             cpl_res,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             neg_o
);

  localparam logic [WIDTH-1:0] ONES = '1;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] pa, pb, core, res;
  logic [5:0]       ctl;

  always_comb begin
    ctl  = {clr_a, cpl_a, clr_b, cpl_b, use_sum, cpl_res};
    pa   = clr_a ? '0 : a_i;
    pa   = cpl_a ? ~pa : pa;
    pb   = clr_b ? '0 : b_i;
    pb   = cpl_b ? ~pb : pb;
    core = use_sum ? (pa + pb) : (pa & pb);
    res  = cpl_res ? ~core : core;
    res_o  = res;
    zero_o = ~|res;
    neg_o  = res[WIDTH-1];

    if (clr_a && cpl_a)
      p_clear_then_cpl_a_r2: assert (pa == ONES);
    if (clr_b && cpl_b)
      p_clear_then_cpl_b_r3: assert (pb == ONES);
    if (ctl == 6'b101010)
      p_const_zero_r9: assert (res == '0 && zero_o);
    if (ctl == 6'b111111)
      p_const_one_r9: assert (res == ONE && !neg_o);
    if (ctl == 6'b111010)
      p_const_minus_r9: assert (res == ONES && neg_o);
    p_flags_exclusive_r7: assert (!(zero_o && neg_o));
    p_sign_flag_r8: assert (neg_o == ($signed(res) < 0));
  end

endmodule

// File: tb/test_flagalu16.sv
module test_flagalu16;
  localparam int W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a = '0, b = '0;
  logic [5:0]   ctl = '0;
  logic [W-1:0] res;
  logic         zf, nf;

  flagalu16 #(.WIDTH(W)) i_flagalu16 (
    .a_i(a), .b_i(b),
    .clr_a(ctl[5]), .cpl_a(ctl[4]), .clr_b(ctl[3]), .cpl_b(ctl[2]),
    .use_sum(ctl[1]), .cpl_res(ctl[0]),
    .res_o(res), .zero_o(zf), .neg_o(nf)
  );

  int checks = 0, fails = 0;

  // entry: {a, b, ctl, expected result}
  localparam int NV = 17;
  localparam logic [53:0] VEC [NV] = '{
    {16'h1234, 16'h0F0F, 6'b101010, 16'h0000},  // R9
    {16'h1234, 16'h0F0F, 6'b111111, 16'h0001},  // R9
    {16'h1234, 16'h0F0F, 6'b111010, 16'hFFFF},  // R9
    {16'h0005, 16'h0003, 6'b010011, 16'h0002},  // R10 a-b
    {16'h0005, 16'h0003, 6'b000111, 16'hFFFE},  // R10 b-a
    {16'h00F0, 16'h0F00, 6'b010101, 16'h0FF0},  // R10 or
    {16'h1234, 16'h0F0F, 6'b000000, 16'h0204},  // R5
    {16'h7FFF, 16'h0001, 6'b000010, 16'h8000},  // R4
    {16'hFFFF, 16'h0001, 6'b000010, 16'h0000},  // R4
    {16'h1234, 16'h5555, 6'b001100, 16'h1234},  // R3
    {16'h1234, 16'h5555, 6'b001101, 16'hEDCB},  // R6
    {16'h0005, 16'h9999, 6'b011111, 16'h0006},  // R10 inc
    {16'h0005, 16'h9999, 6'b001110, 16'h0004},  // R10 dec
    {16'h0005, 16'h9999, 6'b001111, 16'hFFFB},  // R10 neg
    {16'hAAAA, 16'h0003, 6'b110111, 16'h0004},  // R1 R2 b+1
    {16'h0005, 16'h0003, 6'b000010, 16'h0008},  // R4
    {16'h1234, 16'h0000, 6'b101010, 16'h0000}   // R9
  };

  function automatic logic [W-1:0] model(input logic [W-1:0] ma, mb, input logic [5:0] c);
    logic [W-1:0] ta, tb, t;
    ta = c[5] ? '0 : ma;  if (c[4]) ta = ~ta;
    tb = c[3] ? '0 : mb;  if (c[2]) tb = ~tb;
    t  = c[1] ? ta + tb : ta & tb;
    return c[0] ? ~t : t;
  endfunction

  task automatic apply(input logic [W-1:0] va, vb, input logic [5:0] vc,
                       input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    a = va; b = vb; ctl = vc;
    #2;
    checks++;
    if (res !== exp || zf !== (exp == '0) || nf !== exp[W-1]) begin
      fails++;
      $display("FAIL %s ctl=%b a=%h b=%h: got res=%h z=%b n=%b, expected res=%h z=%b n=%b",
               tag, vc, va, vb, res, zf, nf, exp, (exp == '0), exp[W-1]);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog R11: got no finish, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // initial settled state: all-zero inputs, AND of zeros -> zero flag (R5 R7)
    apply('0, '0, 6'b000000, 16'h0000, "R7 initial");
    for (int i = 0; i < NV; i++)
      apply(VEC[i][53:38], VEC[i][37:22], VEC[i][21:16], VEC[i][15:0], "R9/R10 table");
    // corners
    apply(16'h8000, 16'h8000, 6'b000010, 16'h0000, "R4 carry dropped");
    apply(16'h8000, 16'h0000, 6'b000010, 16'h8000, "R8 top bit");
    apply(16'hFFFF, 16'hFFFF, 6'b000000, 16'hFFFF, "R5 and ones");
    apply(16'h0000, 16'h0000, 6'b000001, 16'hFFFF, "R6 invert");
    apply(16'hFFFF, 16'h1234, 6'b101100, 16'h0000, "R1 clear a");
    apply(16'hFFFF, 16'hFFFF, 6'b011100, 16'h0000, "R2 cpl a");
    // R11: same inputs again after a different vector give the same outputs
    apply(16'h0005, 16'h0003, 6'b010011, 16'h0002, "R11 no state");
    // full sweep of control words
    for (int c = 0; c < 64; c++) begin
      apply(16'h1234, 16'h0F0F, 6'(c), model(16'h1234, 16'h0F0F, 6'(c)), "R1-sweep");
      apply(16'h7FFF, 16'h0001, 6'(c), model(16'h7FFF, 16'h0001, 6'(c)), "R4 sweep");
      apply(16'hFFFF, 16'h8000, 6'(c), model(16'hFFFF, 16'h8000, 6'(c)), "R3 sweep");
      apply(16'h0000, 16'hA5A5, 6'(c), model(16'h0000, 16'hA5A5, 6'(c)), "R6 sweep");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule